// File: doc/BRIEF.md
# Half-Duplex Clocked Single-Wire Frame Transceiver

This block is the bit-level layer of a single-wire, half-duplex serial link. Every bit is timed by an external link clock, and the same data line carries traffic in both directions. It comes out of reset listening. It detects a start bit, shifts in a twelve-bit frame and then reports either a good byte or an exception. An exception is a frame error, a parity error or a break.

A controller sets the direction with a mode input. In transmit mode the controller hands over a byte through a valid/ready handshake. The block builds the frame in a shift register and sends it, one bit per clock, with the bits changing on the falling edge. While sending, it compares each bit it drives high with the line level it samples. If the line reads low, the block turns the driver off in the same edge, raises a collision flag and stops the frame.

Any frame, parity or collision error puts the block into a hold state. In hold, the receiver stays active whatever the mode input says. It reports nothing and does not accept a transmit byte until an all-zero break frame arrives.

Top module: `hd_link_phy`

## Requirements
- R1: After reset the block listens: `line_oe_o` is 0, `rx_valid_o` and all four error flags are 0, `link_hold_o` is 0, and `tx_ready_o` is 0 while `tx_mode_i` is 0.
- R2: `tx_ready_o` is 1 only while `tx_mode_i` is 1, no frame is being sent and the block is not in hold. While `tx_mode_i` is 1 and the block is not in hold, frames arriving on the line are ignored.
- R3: A frame has 12 bits in line order. Bit 0 is the start bit (0). Bits 1 to 8 are the data bits, LSB first. Bit 9 is even parity, equal to the XOR of the data bits. Bits 10 and 11 are stop bits (1). The idle level is 1. The receiver takes a 0 sampled on a rising edge as the start bit and samples each later bit on the following rising edges.
- R4: When a good frame ends, `rx_valid_o` is 1 for exactly one cycle with the byte on `rx_data_o`. It is visible after the rising edge that samples the second stop bit, which is 11 edges after the start edge.
- R5: If either stop bit is sampled as 0 and the frame is not all zero, the block raises `err_frame_o` for one cycle instead of `rx_valid_o`.
- R6: If the received parity bit differs from the XOR of the received data bits, the block raises `err_parity_o` for one cycle instead of `rx_valid_o`.
- R7: A frame of twelve 0 bits raises only `err_break_o`, and no frame error. It leaves the block out of hold.
- R8: A byte is accepted on the rising edge where `tx_valid_i` and `tx_ready_o` are both 1. From the next falling edge, `line_oe_o` is 1 and `line_o` presents frame bits 0 to 11, changing on falling edges. `line_oe_o` falls on the rising edge that samples bit 11.
- R9: If a bit driven as 1 is sampled as 0, `line_oe_o` drops on that rising edge and `err_collision_o` is 1 for one cycle. The frame is abandoned. A driven 0 sampled as 0 is not a collision.
- R10: A frame, parity or collision error sets `link_hold_o`. While it is set, the receiver listens regardless of `tx_mode_i`. Non-break frames produce no `rx_valid_o`, no `err_frame_o` and no `err_parity_o`, and `tx_ready_o` is 0. A break frame clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock; rising edge samples the line |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sampled level of the shared data line |
| line_o | output | 1 | Value driven onto the data line |
| line_oe_o | output | 1 | Driver enable for the data line |
| tx_mode_i | input | 1 | 1 requests transmit mode, 0 receive mode |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte on `tx_data_i` is offered |
| tx_ready_o | output | 1 | Block can accept a byte this cycle |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle pulse: good frame received |
| err_frame_o | output | 1 | One-cycle pulse: stop bit read as 0 |
| err_parity_o | output | 1 | One-cycle pulse: parity mismatch |
| err_break_o | output | 1 | One-cycle pulse: all-zero frame |
| err_collision_o | output | 1 | One-cycle pulse: driven 1 read back as 0 |
| link_hold_o | output | 1 | Error hold, cleared by a break |

## Verification
Receive results, good or failed, appear after the rising edge that samples the second stop bit, 11 edges after the start edge. The bench drives each line bit at a falling edge and reads the flags at the falling edge that follows the sample of bit 11. This is the only cycle in which the pulses are valid. Transmit bits appear just after each falling edge, starting with the first falling edge after the load edge, and the bench samples them 1 ns later. A collision removes the enable at the rising edge that samples the bit. The bench therefore checks the enable and the collision pulse at the next falling edge, and checks the hold flag one falling edge later, because it is registered one edge after the collision pulse. All 256 bytes are swept in both directions, with the expected frames computed in the bench from the requirement's bit layout.

// File: rtl/hd_link_pkg.sv
package hd_link_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // line order: start, data lsb-first, even parity, two stops
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d);
    build_frame = {2'b11, ^d, d, 1'b0};
  endfunction
endpackage

// File: rtl/hd_link_rx.sv
module hd_link_rx
  import hd_link_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              line_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              break_o
);
  localparam logic [CNT_W-1:0] PAR_IDX   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] STOP1_IDX = CNT_W'(DATA_W + 1);

  logic              busy_q, par_q, pbit_q, stop1_q, ones_q;
  logic              done_q, ferr_q, perr_q, brk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      pbit_q  <= 1'b0;
      stop1_q <= 1'b0;
      ones_q  <= 1'b0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        if (!line_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          par_q  <= 1'b0;
          ones_q <= 1'b0;
        end
      end else begin
        ones_q <= ones_q | line_i;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q < PAR_IDX) begin
          sh_q  <= {line_i, sh_q[DATA_W-1:1]};
          par_q <= par_q ^ line_i;
        end else if (cnt_q == PAR_IDX) begin
          pbit_q <= line_i;
        end else if (cnt_q == STOP1_IDX) begin
          stop1_q <= line_i;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          brk_q  <= ~(ones_q | line_i);
          ferr_q <= ~stop1_q | ~line_i;
          perr_q <= par_q ^ pbit_q;
        end
      end
    end
  end

  assign done_o       = done_q;
  assign data_o       = sh_q;
  assign frame_err_o  = ferr_q;
  assign parity_err_o = perr_q;
  assign break_o      = brk_q;
endmodule

// File: rtl/hd_link_tx.sv
module hd_link_tx
  import hd_link_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              line_i,
  output logic              busy_o,
  output logic              coll_o,
  output logic              line_o,
  output logic              oe_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, coll_q;
  logic               drv_oe_q, drv_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      coll_q <= 1'b0;
      if (load_i) begin
        sr_q   <= build_frame(data_i);
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && drv_oe_q) begin
        if (drv_bit_q && !line_i) begin
          busy_q <= 1'b0;
          coll_q <= 1'b1;
        end else begin
          sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) busy_q <= 1'b0;
        end
      end
    end
  end

  // launch on falling edge, stable at the sampling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_oe_q  <= 1'b0;
      drv_bit_q <= 1'b1;
    end else begin
      drv_oe_q  <= busy_q;
      drv_bit_q <= sr_q[0];
    end
  end

  assign busy_o = busy_q;
  assign coll_o = coll_q;
  assign line_o = drv_bit_q;
  assign oe_o   = drv_oe_q & busy_q;  // busy drop cuts the driver at once
endmodule

// File: rtl/hd_link_ctrl.sv
module hd_link_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_mode_i,
  input  logic tx_valid_i,
  input  logic tx_busy_i,
  input  logic coll_i,
  input  logic rx_done_i,
  input  logic rx_ferr_i,
  input  logic rx_perr_i,
  input  logic rx_brk_i,
  output logic rx_en_o,
  output logic tx_load_o,
  output logic tx_ready_o,
  output logic rx_valid_o,
  output logic err_frame_o,
  output logic err_parity_o,
  output logic err_break_o,
  output logic hold_o
);
  logic hold_q;
  logic good_done;

  assign good_done    = rx_done_i & ~rx_brk_i & ~hold_q;
  assign rx_valid_o   = good_done & ~rx_ferr_i & ~rx_perr_i;
  assign err_frame_o  = good_done & rx_ferr_i;
  assign err_parity_o = good_done & rx_perr_i;
  assign err_break_o  = rx_done_i & rx_brk_i;

  assign rx_en_o    = (~tx_mode_i | hold_q) & ~tx_busy_i;
  assign tx_ready_o = tx_mode_i & ~tx_busy_i & ~coll_i & ~hold_q;
  assign tx_load_o  = tx_valid_i & tx_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else if (err_break_o) hold_q <= 1'b0;
    else if (err_frame_o || err_parity_o || coll_i) hold_q <= 1'b1;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/hd_link_phy.sv
module hd_link_phy
  import hd_link_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              line_o,
  output logic              line_oe_o,
  input  logic              tx_mode_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              err_frame_o,
  output logic              err_parity_o,
  output logic              err_break_o,
  output logic              err_collision_o,
  output logic              link_hold_o
);
  logic rx_en, rx_done, rx_ferr, rx_perr, rx_brk;
  logic tx_load, tx_busy, tx_coll;

  hd_link_rx u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (rx_en),
    .line_i       (line_i),
    .done_o       (rx_done),
    .data_o       (rx_data_o),
    .frame_err_o  (rx_ferr),
    .parity_err_o (rx_perr),
    .break_o      (rx_brk)
  );

  hd_link_tx u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load),
    .data_i (tx_data_i),
    .line_i (line_i),
    .busy_o (tx_busy),
    .coll_o (tx_coll),
    .line_o (line_o),
    .oe_o   (line_oe_o)
  );

  hd_link_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_mode_i    (tx_mode_i),
    .tx_valid_i   (tx_valid_i),
    .tx_busy_i    (tx_busy),
    .coll_i       (tx_coll),
    .rx_done_i    (rx_done),
    .rx_ferr_i    (rx_ferr),
    .rx_perr_i    (rx_perr),
    .rx_brk_i     (rx_brk),
    .rx_en_o      (rx_en),
    .tx_load_o    (tx_load),
    .tx_ready_o   (tx_ready_o),
    .rx_valid_o   (rx_valid_o),
    .err_frame_o  (err_frame_o),
    .err_parity_o (err_parity_o),
    .err_break_o  (err_break_o),
    .hold_o       (link_hold_o)
  );

  assign err_collision_o = tx_coll;
endmodule

// File: rtl/hd_link_chk.sv
module hd_link_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic line_oe_o,
  input logic tx_mode_i,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic err_frame_o,
  input logic err_parity_o,
  input logic err_break_o,
  input logic err_collision_o,
  input logic link_hold_o
);
  p_ready_needs_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (tx_mode_i && !line_oe_o));

  p_valid_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_result_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_valid_o, err_break_o, err_frame_o | err_parity_o}));

  p_coll_driver_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_collision_o |-> !line_oe_o);

  p_error_sets_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_frame_o || err_parity_o || err_collision_o) |=> link_hold_o);

  p_hold_blocks_tx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_hold_o |-> !tx_ready_o);
endmodule

bind hd_link_phy hd_link_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .line_oe_o       (line_oe_o),
  .tx_mode_i       (tx_mode_i),
  .tx_ready_o      (tx_ready_o),
  .rx_valid_o      (rx_valid_o),
  .err_frame_o     (err_frame_o),
  .err_parity_o    (err_parity_o),
  .err_break_o     (err_break_o),
  .err_collision_o (err_collision_o),
  .link_hold_o     (link_hold_o)
);

// File: tb/sim_hd_link_phy.sv
`timescale 1ns/1ps
module sim_hd_link_phy;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext = 1'b1;
  logic       tx_mode = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       line_w, line_o, line_oe, tx_ready, rx_valid;
  logic       e_frame, e_par, e_brk, e_coll, hold;
  logic [7:0] rx_data;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // wired line: pull-up, either side can pull low
  assign line_w = (line_oe ? line_o : 1'b1) & ext;

  hd_link_phy u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line_w), .line_o(line_o), .line_oe_o(line_oe),
    .tx_mode_i(tx_mode), .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .err_frame_o(e_frame), .err_parity_o(e_par),
    .err_break_o(e_brk), .err_collision_o(e_coll), .link_hold_o(hold)
  );

  function automatic logic [11:0] mk(input logic [7:0] d);
    logic [11:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    f[9]  = ^d;
    f[10] = 1'b1;
    f[11] = 1'b1;
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // leaves the bench at the falling edge where the frame result is visible
  task automatic rx_frame(input logic [11:0] f);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ext = f[i];
    end
    @(negedge clk);
    ext = 1'b1;
  endtask

  function automatic logic [5:0] flags();
    return {rx_valid, e_frame, e_par, e_brk, e_coll, hold};
  endfunction

  task automatic tx_frame(input logic [7:0] d);
    logic [11:0] f;
    f = mk(d);
    @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    chk(tx_ready == 1'b1, "R2 ready", 32'(tx_ready), 1);
    @(negedge clk);
    tx_valid = 1'b0;
    #1;
    for (int i = 0; i < 12; i++) begin
      if (i > 0) begin
        @(negedge clk);
        #1;
      end
      chk(line_oe && line_o == f[i], "R8 tx bit", {d, 4'(i), 3'b0, line_oe, 3'b0, line_o},
          {d, 4'(i), 3'b0, 1'b1, 3'b0, f[i]});
    end
    @(negedge clk);
    #1;
    chk(!line_oe && tx_ready, "R8 end of frame", {line_oe, tx_ready}, 2'b01);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] f;
    repeat (3) @(negedge clk);
    chk(flags() == 6'b0 && !line_oe && !tx_ready, "R1 reset", {flags(), line_oe, tx_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(flags() == 6'b0 && !line_oe && !tx_ready, "R1 after release", {flags(), line_oe, tx_ready}, 0);

    // R3 R4: every byte received
    for (int b = 0; b < 256; b++) begin
      rx_frame(mk(8'(b)));
      chk(rx_valid && rx_data == 8'(b) && flags() == 6'b100000, "R3 R4 rx byte",
          {rx_data, 2'b0, flags()}, {8'(b), 8'h20});
    end
    @(negedge clk);
    chk(!rx_valid, "R4 pulse width", 32'(rx_valid), 0);

    // R6 parity, then R10 hold, then R7 break clears
    for (int b = 0; b < 256; b += 17) begin
      f = mk(8'(b));
      f[9] = ~f[9];
      rx_frame(f);
      chk(e_par && !rx_valid && !e_frame, "R6 parity", flags(), 6'b001000);
      @(negedge clk);
      chk(hold, "R10 hold set", 32'(hold), 1);
      rx_frame(mk(8'(b ^ 8'h3C)));
      chk(flags() == 6'b000001, "R10 frame ignored in hold", flags(), 6'b000001);
      rx_frame(12'h000);
      chk(e_brk && !e_frame, "R7 break in hold", flags(), 6'b000101);
      @(negedge clk);
      chk(!hold, "R10 break clears hold", 32'(hold), 0);
    end

    // R5 frame error, each stop bit
    for (int s = 10; s < 12; s++) begin
      f = mk(8'hA5);
      f[s] = 1'b0;
      rx_frame(f);
      chk(e_frame && !rx_valid && !e_brk, "R5 stop bit zero", flags(), 6'b010000);
      rx_frame(12'h000);
      @(negedge clk);
      chk(!hold, "R7 recover", 32'(hold), 0);
    end

    // R7 break outside hold; near-break is a frame error
    rx_frame(12'h000);
    chk(flags() == 6'b000100, "R7 break only", flags(), 6'b000100);
    @(negedge clk);
    chk(!hold, "R7 no hold", 32'(hold), 0);
    rx_frame(12'h800);
    chk(flags() == 6'b010000, "R5 R7 near-break", flags(), 6'b010000);
    rx_frame(12'h000);
    rx_frame(mk(8'h5A));
    chk(rx_valid && rx_data == 8'h5A, "R7 resumes", {rx_valid, rx_data}, 9'h15A);

    // R2 ignore line in transmit mode
    @(negedge clk);
    tx_mode = 1'b1;
    rx_frame(mk(8'h77));
    chk(flags() == 6'b0, "R2 rx ignored in tx mode", flags(), 0);

    // R8 every byte sent
    for (int b = 0; b < 256; b++) tx_frame(8'(b));

    // R9 collision
    @(negedge clk);
    tx_data = 8'hFF;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    ext = 1'b0;  // low during start bit: no collision
    #1;
    chk(line_oe, "R9 start with external low", 32'(line_oe), 1);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      ext = (i == 3) ? 1'b0 : 1'b1;
      #1;
      chk(line_oe && !e_coll, "R9 no collision yet", {line_oe, e_coll}, 2'b10);
    end
    @(negedge clk);
    ext = 1'b1;
    #1;
    chk(!line_oe && e_coll && !tx_ready, "R9 collision", {line_oe, e_coll, tx_ready}, 3'b010);
    @(negedge clk);
    chk(hold && !tx_ready && !e_coll, "R10 hold after collision", {hold, tx_ready, e_coll}, 3'b100);
    rx_frame(mk(8'h11));
    chk(flags() == 6'b000001, "R10 ignore in hold tx mode", flags(), 6'b000001);
    rx_frame(12'h000);
    chk(e_brk, "R10 rx listens in hold", flags(), 6'b000101);
    @(negedge clk);
    chk(!hold && tx_ready, "R10 leave hold", {hold, tx_ready}, 2'b01);
    tx_frame(8'hC3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule